// File: doc/BRIEF.md
# Multi-Word Register Transfer Sequencer

This block moves a contiguous run of general registers to or from memory, one 32-bit word per register. A transfer is started with a first register index, a base address and a direction. It then walks upward from that register through the highest register. The memory area begins at the base address with its two low bits cleared and grows by four bytes per register. Each word goes out as a single request on a memory port that allows one access in flight. A load writes the returned word into a register file write port. A store reads the register through a combinational read port and sends it with the request.

A run can cross a page boundary, so any single word can fault. On a fault response the sequencer writes nothing for that word and stops. It pulses a fault output and keeps the faulting address, the index of the register that did not complete, and the direction. The fault handler can read all three. A restart request then resumes the run at exactly that word and register, without repeating the words that already completed.

Top module: `lsm_seq`

## Requirements
- R1: While rst_ni is low, and after it rises until the first start, busy_o, done_o, fault_o, mem_req_o and rf_we_o are all low.
- R2: A transfer started at register index s issues word requests for registers s, s+1, ..., 15 in that order, so 16-s requests when no fault occurs. Each request address is the base address with bits [1:0] forced to 0, plus 4 per register already done.
- R3: For a load (store_i = 0), register k (k >= s) receives the word read at aligned base + 4*(k-s). Registers below s are not written.
- R4: For a store (store_i = 1), the word at aligned base + 4*(k-s) receives the value of register k. Memory outside the area is not written.
- R5: busy_o goes high on the clock edge that accepts a start and stays high until the run ends. done_o is a single-cycle pulse in the cycle after the last word completes without fault.
- R6: A fault response ends the run. fault_o pulses for one cycle with busy_o low. flt_addr_o holds the faulting word address, flt_reg_o the index of that register, and flt_store_o the direction (1 = store). All three are held until the next fault.
- R7: After a fault, no register at or above the faulting index is written by a load. No store request is issued for those registers.
- R8: restart_i while idle resumes at the recorded register index, address and direction. It issues only the remaining 16-index requests and ends with done_o.
- R9: start_i and restart_i are ignored while busy_o is high. If both are high while idle, start_i takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new transfer (idle only) |
| restart_i | input | 1 | Resume from the recorded fault state (idle only) |
| store_i | input | 1 | Direction of a new transfer: 1 = store, 0 = load |
| start_reg_i | input | 4 | First register index |
| base_addr_i | input | 32 | Base byte address; the low two bits are ignored |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse: run finished without fault |
| fault_o | output | 1 | One-cycle pulse: run stopped on a fault |
| flt_addr_o | output | 32 | Recorded faulting word address |
| flt_reg_o | output | 4 | Recorded index of the register not completed |
| flt_store_o | output | 1 | Recorded direction of the faulted run |
| mem_req_o | output | 1 | Word request, one cycle per access |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word-aligned request address |
| mem_wdata_o | output | 32 | Write data for a store |
| mem_rsp_valid_i | input | 1 | Response for the outstanding request |
| mem_rsp_fault_i | input | 1 | Response reports a page fault |
| mem_rsp_rdata_i | input | 32 | Read data for a load |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |

## Verification
The assertions assume that memory sends exactly one response per request, and only while that request is outstanding. A response at any other time is flagged as a protocol violation. The bench memory model meets this by answering each request one cycle later and never volunteering a response. It drops any pending answer when reset is asserted, and it keeps reset low until after the next falling edge so the stale response is gone before the check is enabled again. Faults are injected only at one chosen word address per run. The restart is issued only after that fault has been cleared, so each resumed run finishes without fault.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} lsm_state_e;
  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/lsm_cursor.sv
module lsm_cursor import lsm_pkg::*; #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              ld_store_i,
  input  logic              adv_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              store_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WORD_BYTES - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              store_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      addr_q  <= '0;
      store_q <= 1'b0;
    end else if (load_i) begin
      idx_q   <= ld_idx_i;
      addr_q  <= ld_addr_i & ALIGN_MASK;  // silent word alignment
      store_q <= ld_store_i;
    end else if (adv_i) begin
      idx_q   <= idx_q + 1'b1;
      addr_q  <= addr_q + ADDR_W'(WORD_BYTES);
    end
  end

  assign idx_o   = idx_q;
  assign addr_o  = addr_q;
  assign store_o = store_q;
  assign last_o  = (idx_q == LAST_IDX);
endmodule

// File: rtl/lsm_fault_rec.sv
module lsm_fault_rec #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              store_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              store_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o   <= '0;
      addr_o  <= '0;
      store_o <= 1'b0;
    end else if (capture_i) begin
      idx_o   <= idx_i;
      addr_o  <= addr_i;
      store_o <= store_i;
    end
  end
endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl import lsm_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic restart_i,
  input  logic rsp_valid_i,
  input  logic rsp_fault_i,
  input  logic last_i,
  output logic busy_o,
  output logic req_o,
  output logic load_o,
  output logic from_rec_o,
  output logic adv_o,
  output logic commit_o,
  output logic capture_o,
  output logic done_o,
  output logic fault_o
);
  lsm_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    from_rec_o = 1'b0;
    adv_o      = 1'b0;
    commit_o   = 1'b0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_REQ;
        end else if (restart_i) begin
          load_o     = 1'b1;
          from_rec_o = 1'b1;
          state_d    = ST_REQ;
        end
      end
      ST_REQ: state_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_valid_i) begin
          if (rsp_fault_i) begin
            capture_o = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            commit_o = 1'b1;
            if (last_i) state_d = ST_IDLE;
            else begin
              adv_o   = 1'b1;
              state_d = ST_REQ;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= commit_o & last_i;
      fault_o <= capture_o;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign req_o  = (state_q == ST_REQ);

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_req_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy_o);
  assert_fault_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!busy_o && !done_o));
  // Input protocol: a response only while a request is outstanding.
  assert_rsp_in_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> (state_q == ST_WAIT));
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq import lsm_pkg::*; #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              restart_i,
  input  logic              store_i,
  input  logic [IDX_W-1:0]  start_reg_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] flt_addr_o,
  output logic [IDX_W-1:0]  flt_reg_o,
  output logic              flt_store_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic              mem_rsp_fault_i,
  input  logic [DATA_W-1:0] mem_rsp_rdata_i,
  output logic [IDX_W-1:0]  rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o
);
  logic              load, from_rec, adv, commit, capture, last;
  logic [IDX_W-1:0]  cur_idx, ld_idx;
  logic [ADDR_W-1:0] cur_addr, ld_addr;
  logic              cur_store, ld_store;

  lsm_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .restart_i   (restart_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_fault_i (mem_rsp_fault_i),
    .last_i      (last),
    .busy_o      (busy_o),
    .req_o       (mem_req_o),
    .load_o      (load),
    .from_rec_o  (from_rec),
    .adv_o       (adv),
    .commit_o    (commit),
    .capture_o   (capture),
    .done_o      (done_o),
    .fault_o     (fault_o)
  );

  // Resume point comes from the fault record, otherwise from the ports.
  assign ld_idx   = from_rec ? flt_reg_o   : start_reg_i;
  assign ld_addr  = from_rec ? flt_addr_o  : base_addr_i;
  assign ld_store = from_rec ? flt_store_o : store_i;

  lsm_cursor #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_cursor (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .ld_idx_i   (ld_idx),
    .ld_addr_i  (ld_addr),
    .ld_store_i (ld_store),
    .adv_i      (adv),
    .idx_o      (cur_idx),
    .addr_o     (cur_addr),
    .store_o    (cur_store),
    .last_o     (last)
  );

  lsm_fault_rec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_frec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .idx_i     (cur_idx),
    .addr_i    (cur_addr),
    .store_i   (cur_store),
    .idx_o     (flt_reg_o),
    .addr_o    (flt_addr_o),
    .store_o   (flt_store_o)
  );

  assign mem_we_o    = cur_store;
  assign mem_addr_o  = cur_addr;
  assign mem_wdata_o = rf_rdata_i;
  assign rf_raddr_o  = cur_idx;
  assign rf_waddr_o  = cur_idx;
  assign rf_wdata_o  = mem_rsp_rdata_i;
  assign rf_we_o     = commit & ~cur_store;

  assert_addr_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));
  assert_no_write_on_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rsp_valid_i && mem_rsp_fault_i) |-> !rf_we_o);
  assert_record_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> ($stable(flt_reg_o) && $stable(flt_addr_o) && $stable(flt_store_o)));
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !rf_we_o));
endmodule

// File: tb/sim_lsm_seq.sv
module sim_lsm_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  typedef struct packed {
    logic        st;
    logic [3:0]  sreg;
    logic [11:0] base;
    logic        fen;
    logic [11:0] faddr;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0,  12'h000, 1'b0, 12'h000},
    '{1'b1, 4'd4,  12'h043, 1'b0, 12'h000},
    '{1'b0, 4'd15, 12'h0A2, 1'b0, 12'h000},
    '{1'b0, 4'd2,  12'h038, 1'b1, 12'h040},
    '{1'b1, 4'd8,  12'h07D, 1'b1, 12'h080},
    '{1'b1, 4'd0,  12'h010, 1'b0, 12'h000},
    '{1'b0, 4'd10, 12'h0C0, 1'b1, 12'h0C0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, restart_i = 1'b0, store_i = 1'b0;
  logic [3:0]  start_reg_i = '0;
  logic [31:0] base_addr_i = '0;
  logic        busy_o, done_o, fault_o, flt_store_o;
  logic [31:0] flt_addr_o;
  logic [3:0]  flt_reg_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_rsp_valid_i = 1'b0, mem_rsp_fault_i = 1'b0;
  logic [31:0] mem_rsp_rdata_i = '0;
  logic [3:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata_i, rf_wdata_o;
  logic        rf_we_o;

  logic [31:0] mem [64];
  logic [31:0] rf  [16];
  logic        init_go = 1'b0;
  int          init_v = 0;
  logic        flt_arm = 1'b0;
  logic [31:0] flt_at = '0;
  int          req_total = 0;
  logic        pend = 1'b0, pend_fault = 1'b0;
  logic [31:0] pend_data = '0;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsm_seq u0 (.*, .clk_i(clk));

  function automatic logic [31:0] mem_init(int v, int w);
    return 32'h5A00_0000 + 32'(v) * 32'h1_0000 + 32'(w);
  endfunction
  function automatic logic [31:0] rf_init(int v, int i);
    return 32'h3C00_0000 + 32'(v) * 32'h1_0000 + 32'(i);
  endfunction

  assign rf_rdata_i = rf[rf_raddr_o];

  always @(posedge clk) begin
    if (init_go) begin
      for (int i = 0; i < 16; i++) rf[i] <= rf_init(init_v, i);
    end else if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
  end

  // Memory model: answers one cycle after each request.
  always @(negedge clk) begin
    if (init_go) for (int w = 0; w < 64; w++) mem[w] = mem_init(init_v, w);
    mem_rsp_valid_i = 1'b0;
    mem_rsp_fault_i = 1'b0;
    if (!rst_ni) pend = 1'b0;
    else if (pend) begin
      mem_rsp_valid_i = 1'b1;
      mem_rsp_fault_i = pend_fault;
      mem_rsp_rdata_i = pend_data;
      pend = 1'b0;
    end else if (mem_req_o) begin
      req_total++;
      pend       = 1'b1;
      pend_fault = flt_arm && (mem_addr_o == flt_at);
      pend_data  = pend_fault ? 32'h0 : mem[mem_addr_o[7:2]];
      if (mem_we_o && !pend_fault) mem[mem_addr_o[7:2]] = mem_wdata_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_init(int v);
    init_v = v;
    init_go = 1'b1;
    @(posedge clk); @(negedge clk); @(posedge clk);
    init_go = 1'b0;
    @(negedge clk);
  endtask

  task automatic op_start(logic st, logic [3:0] s, logic [31:0] b, logic rs);
    start_i = 1'b1; restart_i = rs; store_i = st; start_reg_i = s; base_addr_i = b;
    @(negedge clk);
    start_i = 1'b0; restart_i = 1'b0;
    chk("R5 busy after start", 32'(busy_o), 32'd1);
  endtask

  task automatic op_restart();
    restart_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_fault);
    got_done = 1'b0; got_fault = 1'b0;
    for (int c = 0; c < 200; c++) begin
      if (done_o) begin
        got_done = 1'b1;
        chk("R5 not busy at done", 32'(busy_o), 32'd0);
        @(negedge clk);
        chk("R5 done one cycle", 32'(done_o), 32'd0);
        return;
      end
      if (fault_o) begin
        got_fault = 1'b1;
        return;
      end
      @(negedge clk);
    end
    chk("R5 run timeout", 32'd1, 32'd0);
  endtask

  task automatic run_vec(int v);
    vec_t t = VECS[v];
    bit gd, gf;
    int s = int'(t.sreg);
    int base_al = int'(t.base) & ~3;
    int w0 = base_al >> 2;
    int r0;
    do_init(v);
    flt_arm = t.fen;
    flt_at = 32'(t.faddr);
    r0 = req_total;
    op_start(t.st, t.sreg, 32'(t.base), 1'b0);
    wait_end(gd, gf);
    if (t.fen) begin
      int fidx = s + ((int'(t.faddr) - base_al) >> 2);
      int fw = int'(t.faddr) >> 2;
      chk("R6 fault pulse", 32'(gf), 32'd1);
      chk("R6 busy low", 32'(busy_o), 32'd0);
      chk("R6 fault addr", flt_addr_o, 32'(t.faddr));
      chk("R6 fault reg", 32'(flt_reg_o), 32'(fidx));
      chk("R6 fault dir", 32'(flt_store_o), 32'(t.st));
      chk("R2 requests to fault", 32'(req_total - r0), 32'(fidx - s + 1));
      for (int k = fidx; k < 16; k++) begin
        if (!t.st) chk("R7 reg untouched", rf[k], rf_init(v, k));
        else chk("R7 mem untouched", mem[fw + k - fidx], mem_init(v, fw + k - fidx));
      end
      @(negedge clk);
      chk("R6 fault one cycle", 32'(fault_o), 32'd0);
      flt_arm = 1'b0;
      r0 = req_total;
      op_restart();
      chk("R8 busy after restart", 32'(busy_o), 32'd1);
      wait_end(gd, gf);
      chk("R8 restart done", 32'(gd), 32'd1);
      chk("R8 remaining requests", 32'(req_total - r0), 32'(16 - fidx));
    end else begin
      chk("R5 done seen", 32'(gd), 32'd1);
      chk("R2 request count", 32'(req_total - r0), 32'(16 - s));
    end
    for (int k = 0; k < 16; k++) begin
      if (!t.st) begin
        if (k >= s) chk("R3 loaded reg", rf[k], mem_init(v, w0 + k - s));
        else chk("R3 low reg untouched", rf[k], rf_init(v, k));
      end else if (k >= s) chk("R4 stored word", mem[w0 + k - s], rf_init(v, k));
    end
    if (t.st && w0 > 0) chk("R4 word below area", mem[w0 - 1], mem_init(v, w0 - 1));
  endtask

  initial begin
    bit gd, gf;
    int r0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy_o), 32'd0);
    chk("R1 req in reset", 32'(mem_req_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy_o), 32'd0);
    chk("R1 done after reset", 32'(done_o), 32'd0);
    chk("R1 fault after reset", 32'(fault_o), 32'd0);
    chk("R1 rf we after reset", 32'(rf_we_o), 32'd0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R9: start and restart while busy are ignored
    do_init(7);
    r0 = req_total;
    op_start(1'b0, 4'd12, 32'h20, 1'b0);
    start_i = 1'b1; restart_i = 1'b1; store_i = 1'b1; start_reg_i = 4'd0; base_addr_i = 32'h80;
    @(negedge clk);
    start_i = 1'b0; restart_i = 1'b0;
    wait_end(gd, gf);
    chk("R9 busy start ignored done", 32'(gd), 32'd1);
    chk("R9 request count", 32'(req_total - r0), 32'd4);
    for (int k = 12; k < 16; k++) chk("R9 original load kept", rf[k], mem_init(7, 8 + k - 12));
    chk("R9 no stray store", mem[32], mem_init(7, 32));

    // R9: start wins over restart when both arrive in idle
    do_init(8);
    r0 = req_total;
    op_start(1'b0, 4'd14, 32'h0, 1'b1);
    wait_end(gd, gf);
    chk("R9 start priority done", 32'(gd), 32'd1);
    chk("R9 start priority count", 32'(req_total - r0), 32'd2);
    chk("R9 start priority reg14", rf[14], mem_init(8, 0));
    chk("R9 start priority reg15", rf[15], mem_init(8, 1));

    // R1: reset in mid-run
    do_init(9);
    op_start(1'b1, 4'd0, 32'h0, 1'b0);
    repeat (2) @(negedge clk);
    #1 rst_ni = 1'b0;
    #1 chk("R1 busy on reset", 32'(busy_o), 32'd0);
    chk("R1 req on reset", 32'(mem_req_o), 32'd0);
    repeat (2) @(negedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 busy after mid reset", 32'(busy_o), 32'd0);
    chk("R1 done after mid reset", 32'(done_o), 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule